// File: doc/BRIEF.md
# Self-Detecting Host Bus Interface

This block is the 8-bit slave port that a small microcontroller uses to reach a peripheral's register file. Such hosts come in two strobe styles: separate active-low read and write strobes, or a direction line paired with one active-low data strobe. They also come in two bus styles: a dedicated address bus, or address and data sharing the low data lines under an address-latch-enable. The block has no configuration pins for either choice. It starts in separate-strobe, multiplexed operation and watches the first accesses after hardware reset. The first write access decides the strobe style. Any high level on the A0/mode pin while the block is selected decides the bus style. The first read access makes both choices final until the next reset.

All bus pins pass through a synchronizer into the core clock. Each bus cycle produces one single-cycle pulse toward the register file. A write gives a write pulse when the strobe ends, carrying the last sampled data and address. A read gives a read pulse when the strobe begins, and the register file's read data is driven back out while the read lasts. An optional high-speed read mode captures the address at a fixed delay into the strobe and fires the read pulse a further delay later. A clear-on-read register downstream is then only affected by a strobe held long enough for a stable decode.

Top module: `hb_autobus`

## Requirements
- R1: After reset the block reports separate-strobe style (`strobe_ds`=0), multiplexed bus (`nonmux`=0) and not locked (`locked`=0), with `ad_oe`, `reg_rd` and `reg_wr` low.
- R2: The first write access that ends while undecided sets the strobe style. If `rd_ds_n` and `wr_dir` were both low together while `cs_n` was low, it becomes direction/strobe (`strobe_ds`=1). Otherwise it becomes separate strobes (`strobe_ds`=0).
- R3: Before lock, a high level on `a0_mux` while `cs_n` is low selects a non-multiplexed bus (`nonmux`=1). A host that holds `a0_mux` low keeps the multiplexed bus.
- R4: The first read request (`cs_n` low, `rd_ds_n` low, `wr_dir` high) sets `locked`=1. After that, `strobe_ds` and `nonmux` do not change until reset, whatever activity follows.
- R5: In separate-strobe style, `cs_n` low with `wr_dir` low is a write. `reg_wr` pulses once after it ends, and `reg_wdata` and `reg_addr` hold the last value sampled during it. `cs_n` low with `rd_ds_n` low is a read, and `reg_rd` pulses once at its start.
- R6: In direction/strobe style, a write needs `rd_ds_n` low with `wr_dir` low, and a read needs `rd_ds_n` low with `wr_dir` high. `wr_dir` low without the data strobe produces no pulse.
- R7: In multiplexed mode the register address is `ad_in[2:0]`, taken while `a2_ale` is high and held after it falls. In non-multiplexed mode the address is {`a2_ale`,`a1`,`a0_mux`}.
- R8: Every bus cycle yields exactly one pulse of the matching kind. `reg_rd` and `reg_wr` never both pulse, and neither stays high two cycles in a row.
- R9: With `fast_rd_en`=1, the read address is captured RD_DLY1 cycles after the synchronized read begins. `reg_rd` fires RD_DLY2 cycles later, only if the read is still held. A shorter read gives no pulse, and address changes after capture do not reach `reg_addr`.
- R10: While a read is active, `ad_oe` is high and `ad_out` carries `reg_rdata`. A read pulse only occurs with `ad_oe` high.
- R11: Hardware reset clears the learned styles and the lock, so a later host of another style is learned afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| fast_rd_en | input | 1 | Selects delayed-sample high-speed read mode |
| cs_n | input | 1 | Active-low chip select |
| rd_ds_n | input | 1 | Read strobe, or data strobe in direction/strobe style |
| wr_dir | input | 1 | Write strobe, or direction (1 = read) |
| a0_mux | input | 1 | Address bit 0, held low by a multiplexed host |
| a1 | input | 1 | Address bit 1 (unused when multiplexed) |
| a2_ale | input | 1 | Address bit 2, or address-latch-enable when multiplexed |
| ad_in | input | 8 | Data in, low three bits carry address when multiplexed |
| ad_out | output | 8 | Read data toward the host |
| ad_oe | output | 1 | Output enable for the data bus |
| reg_addr | output | 3 | Decoded register address |
| reg_wr | output | 1 | Single-cycle write pulse |
| reg_rd | output | 1 | Single-cycle read pulse |
| reg_wdata | output | 8 | Write data held with the write pulse |
| reg_rdata | input | 8 | Read data from the register file for `reg_addr` |
| strobe_ds | output | 1 | 1 = direction/strobe style learned |
| nonmux | output | 1 | 1 = non-multiplexed bus learned |
| locked | output | 1 | Style decisions are final |

## Verification
Every cycle, the assertions check the following. Read and write pulses are one cycle wide and never coincide. The learned styles stay frozen once locked. A read pulse only appears while the data bus is driven, and in high-speed mode only after the read has already been held. Which style the learner picks from a given opening sequence, and the address, data and read values carried by each pulse, can only be shown by the bench. It plays hosts of both strobe styles and both bus styles through reset. It also checks that short high-speed reads and lone direction changes produce no pulse.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int HB_DW = 8;
  localparam int HB_AW = 3;
  localparam int HB_PINW = 6 + HB_DW;

  // synchronized view of the host pins, msb first
  typedef struct packed {
    logic             cs_n;
    logic             rd_n;
    logic             wr_n;
    logic             a0;
    logic             a1;
    logic             a2;
    logic [HB_DW-1:0] ad;
  } hb_pins_t;

  // idle levels: strobes high, A1 pulled up, bus lines pulled up
  localparam logic [HB_PINW-1:0] HB_PIN_IDLE = {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, {HB_DW{1'b1}}};
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_detect.sv
module hb_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic a0,
  output logic strobe_ds,
  output logic nonmux,
  output logic locked
);
  logic sel, wwin, rdreq;
  logic s_lock, win_q, both_q, ds_q, nm_q, m_lock;

  assign sel   = ~cs_n;
  assign wwin  = sel & ~wr_n;
  assign rdreq = sel & ~rd_n & wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_lock <= 1'b0;
      win_q  <= 1'b0;
      both_q <= 1'b0;
      ds_q   <= 1'b0;
      nm_q   <= 1'b0;
      m_lock <= 1'b0;
    end else begin
      if (!s_lock) begin
        win_q <= wwin;
        if (wwin && !rd_n) both_q <= 1'b1;
        if (win_q && !wwin) begin
          ds_q   <= both_q;
          s_lock <= 1'b1;
        end
      end
      if (!m_lock) begin
        if (sel && a0) nm_q <= 1'b1;
        if (rdreq) begin
          m_lock <= 1'b1;
          s_lock <= 1'b1;
        end
      end
    end
  end

  assign strobe_ds = ds_q;
  assign nonmux    = nm_q;
  assign locked    = m_lock;
endmodule

// File: rtl/hb_decode.sv
module hb_decode
  import hb_pkg::*;
#(
  parameter int RD_DLY1 = 2,
  parameter int RD_DLY2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hb_pins_t         p,
  input  logic             strobe_ds,
  input  logic             nonmux,
  input  logic             fast_rd_en,
  output logic [HB_AW-1:0] reg_addr,
  output logic             reg_wr,
  output logic             reg_rd,
  output logic [HB_DW-1:0] reg_wdata,
  output logic             ad_oe
);
  localparam int FIRE = RD_DLY1 + RD_DLY2;
  localparam int CW   = $clog2(FIRE + 2);
  localparam logic [CW-1:0] CAP_V  = CW'(RD_DLY1);
  localparam logic [CW-1:0] FIRE_V = CW'(FIRE);
  localparam logic [CW-1:0] SAT_V  = CW'(FIRE + 1);

  logic             sel, rd_act, wr_act, rd_q, wr_q;
  logic [HB_AW-1:0] lat_q, live, addr_q;
  logic [HB_DW-1:0] wd_q;
  logic [CW-1:0]    cnt;
  logic             cap_now, fire_now;

  assign sel    = ~p.cs_n;
  assign rd_act = sel & ~p.rd_n & p.wr_n;
  assign wr_act = strobe_ds ? (sel & ~p.rd_n & ~p.wr_n) : (sel & ~p.wr_n);
  assign live   = nonmux ? {p.a2, p.a1, p.a0} : lat_q;

  assign cap_now  = rd_act && (cnt == CAP_V);
  assign fire_now = rd_act && (cnt == FIRE_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (p.a2) lat_q <= p.ad[HB_AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!rd_act) cnt <= '0;
    else if (cnt != SAT_V) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      ad_oe     <= 1'b0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      addr_q    <= '0;
      wd_q      <= '0;
    end else begin
      rd_q   <= rd_act;
      wr_q   <= wr_act;
      ad_oe  <= rd_act;
      reg_wr <= wr_q & ~wr_act;
      reg_rd <= fast_rd_en ? fire_now : (rd_act & ~rd_q);
      if (wr_act) wd_q <= p.ad;
      if (wr_act || (rd_act && !fast_rd_en) || (cap_now && fast_rd_en))
        addr_q <= live;
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = wd_q;
endmodule

// File: rtl/hb_autobus.sv
module hb_autobus
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RD_DLY1 = 2,
  parameter int RD_DLY2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_rd_en,
  input  logic             cs_n,
  input  logic             rd_ds_n,
  input  logic             wr_dir,
  input  logic             a0_mux,
  input  logic             a1,
  input  logic             a2_ale,
  input  logic [HB_DW-1:0] ad_in,
  output logic [HB_DW-1:0] ad_out,
  output logic             ad_oe,
  output logic [HB_AW-1:0] reg_addr,
  output logic             reg_wr,
  output logic             reg_rd,
  output logic [HB_DW-1:0] reg_wdata,
  input  logic [HB_DW-1:0] reg_rdata,
  output logic             strobe_ds,
  output logic             nonmux,
  output logic             locked
);
  logic [HB_PINW-1:0] raw, synced;
  hb_pins_t           p;

  assign raw = {cs_n, rd_ds_n, wr_dir, a0_mux, a1, a2_ale, ad_in};

  hb_sync #(.W(HB_PINW), .STAGES(SYNC_STAGES), .RST(HB_PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  assign p = hb_pins_t'(synced);

  hb_detect u_detect (
    .clk(clk), .rst_n(rst_n),
    .cs_n(p.cs_n), .rd_n(p.rd_n), .wr_n(p.wr_n), .a0(p.a0),
    .strobe_ds(strobe_ds), .nonmux(nonmux), .locked(locked)
  );

  hb_decode #(.RD_DLY1(RD_DLY1), .RD_DLY2(RD_DLY2)) u_decode (
    .clk(clk), .rst_n(rst_n), .p(p),
    .strobe_ds(strobe_ds), .nonmux(nonmux), .fast_rd_en(fast_rd_en),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .ad_oe(ad_oe)
  );

  assign ad_out = ad_oe ? reg_rdata : '0;
endmodule

// File: rtl/hb_autobus_chk.sv
module hb_autobus_chk (
  input logic clk,
  input logic rst_n,
  input logic fast_rd_en,
  input logic ad_oe,
  input logic reg_wr,
  input logic reg_rd,
  input logic strobe_ds,
  input logic nonmux,
  input logic locked
);
  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(reg_rd && reg_wr));
  // R8
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr);
  // R8
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd);
  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(strobe_ds) && $stable(nonmux)));
  // R10
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |-> ad_oe);
  // R9
  fast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && fast_rd_en) |-> $past(ad_oe));
endmodule

bind hb_autobus hb_autobus_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fast_rd_en(fast_rd_en), .ad_oe(ad_oe),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .strobe_ds(strobe_ds),
  .nonmux(nonmux), .locked(locked)
);

// File: tb/hb_autobus_test.sv
module hb_autobus_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, fast_rd_en = 1'b0;
  logic cs_n = 1'b1, rd_ds_n = 1'b1, wr_dir = 1'b1, a0_mux = 1'b0, a1 = 1'b1, a2_ale = 1'b0;
  logic [7:0] ad_in = 8'hFF, ad_out, reg_wdata, reg_rdata;
  logic [2:0] reg_addr;
  logic ad_oe, reg_wr, reg_rd, strobe_ds, nonmux, locked;

  int n_cmp = 0, n_bad = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [2:0] last_wa, last_ra;
  logic [7:0] last_wd;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_autobus uut (
    .clk(clk), .rst_n(rst_n), .fast_rd_en(fast_rd_en),
    .cs_n(cs_n), .rd_ds_n(rd_ds_n), .wr_dir(wr_dir),
    .a0_mux(a0_mux), .a1(a1), .a2_ale(a2_ale), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .strobe_ds(strobe_ds), .nonmux(nonmux), .locked(locked)
  );

  function automatic logic [7:0] reg_model(input logic [2:0] a);
    return 8'hA5 ^ {a, 2'b01, a};
  endfunction

  assign reg_rdata = reg_model(reg_addr);

  // pulse monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr) begin wr_cnt++; last_wa = reg_addr; last_wd = reg_wdata; end
      if (reg_rd) begin rd_cnt++; last_ra = reg_addr; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fast_rd_en = 1'b0;
    cs_n = 1'b1; rd_ds_n = 1'b1; wr_dir = 1'b1; a0_mux = 1'b0; a1 = 1'b1; a2_ale = 1'b0; ad_in = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic access(input bit ds, input bit mux, input bit wr, input logic [2:0] addr,
                        input logic [7:0] data, input int hold, input int chg_at,
                        input logic [2:0] addr2, output logic [7:0] seen);
    @(negedge clk);
    if (mux) begin
      a0_mux = 1'b0; a1 = 1'b1; ad_in = {5'b0, addr}; a2_ale = 1'b1;
      repeat (3) @(negedge clk);
      a2_ale = 1'b0;
      repeat (2) @(negedge clk);
    end else begin
      {a2_ale, a1, a0_mux} = addr;
    end
    ad_in = wr ? data : 8'hFF;
    cs_n = 1'b0;
    if (wr) begin
      wr_dir = 1'b0;
      if (ds) rd_ds_n = 1'b0;
    end else begin
      wr_dir = 1'b1; rd_ds_n = 1'b0;
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (i == chg_at && !mux) {a2_ale, a1, a0_mux} = addr2;
    end
    seen = ad_out;
    rd_ds_n = 1'b1;
    if (!ds) wr_dir = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; wr_dir = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_wr(input string req, input bit ds, input bit mux,
                       input logic [2:0] addr, input logic [7:0] data);
    int w0 = wr_cnt, r0 = rd_cnt;
    logic [7:0] s;
    access(ds, mux, 1'b1, addr, data, 6, -1, addr, s);
    chk({req, " R8 write pulse count"}, wr_cnt - w0, 1);
    chk({req, " R8 no read pulse"}, rd_cnt - r0, 0);
    chk({req, " R7 write address"}, int'(last_wa), int'(addr));
    chk({req, " write data"}, int'(last_wd), int'(data));
  endtask

  task automatic do_rd(input string req, input bit ds, input bit mux, input logic [2:0] addr);
    int w0 = wr_cnt, r0 = rd_cnt;
    logic [7:0] s;
    access(ds, mux, 1'b0, addr, 8'h00, 8, -1, addr, s);
    chk({req, " R8 read pulse count"}, rd_cnt - r0, 1);
    chk({req, " R8 no write pulse"}, wr_cnt - w0, 0);
    chk({req, " R7 read address"}, int'(last_ra), int'(addr));
    chk({req, " R10 read data"}, int'(s), int'(reg_model(addr)));
  endtask

  task automatic random_mix(input string req, input bit ds, input bit mux, input int n);
    for (int k = 0; k < n; k++) begin
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [7:0] d = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 1) do_wr(req, ds, mux, a, d);
      else do_rd(req, ds, mux, a);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    int w0, r0;
    void'($urandom(32'd20417));
    do_reset();

    // R1 reset state
    chk("R1 strobe_ds", strobe_ds, 0);
    chk("R1 nonmux", nonmux, 0);
    chk("R1 locked", locked, 0);
    chk("R1 ad_oe", ad_oe, 0);
    chk("R1 pulses", {reg_rd, reg_wr}, 0);

    // separate strobes, multiplexed host: R2 R3 R5 R7
    do_wr("R5 rw/mux first", 1'b0, 1'b1, 3'd3, 8'h5A);
    chk("R2 rw style kept", strobe_ds, 0);
    chk("R3 mux kept", nonmux, 0);
    chk("R4 not yet locked", locked, 0);
    do_rd("R5 rw/mux first read", 1'b0, 1'b1, 3'd5);
    chk("R4 locked after read", locked, 1);
    random_mix("R5 rw/mux random", 1'b0, 1'b1, 20);
    // R4: A0 high after lock must not switch bus style
    @(negedge clk); a0_mux = 1'b1; cs_n = 1'b0; repeat (6) @(negedge clk);
    cs_n = 1'b1; a0_mux = 1'b0; repeat (4) @(negedge clk);
    chk("R4 nonmux frozen", nonmux, 0);
    chk("R4 strobe frozen", strobe_ds, 0);

    // R11 reset then direction/strobe, non-multiplexed host
    do_reset();
    chk("R11 relearn cleared lock", locked, 0);
    w0 = wr_cnt;
    access(1'b1, 1'b0, 1'b1, 3'd1, 8'hC3, 6, -1, 3'd1, s);
    chk("R8 first ds write one pulse", wr_cnt - w0, 1);
    chk("R2 ds style learned", strobe_ds, 1);
    chk("R3 nonmux learned", nonmux, 1);
    do_rd("R6 ds/nonmux first read", 1'b1, 1'b0, 3'd6);
    chk("R4 locked ds", locked, 1);
    do_wr("R6 ds/nonmux write", 1'b1, 1'b0, 3'd7, 8'h81);
    random_mix("R6 ds/nonmux random", 1'b1, 1'b0, 20);

    // R6 direction low without data strobe: no pulse
    w0 = wr_cnt; r0 = rd_cnt;
    @(negedge clk); cs_n = 1'b0; wr_dir = 1'b0; repeat (6) @(negedge clk);
    cs_n = 1'b1; wr_dir = 1'b1; repeat (6) @(negedge clk);
    chk("R6 lone direction no write", wr_cnt - w0, 0);
    chk("R6 lone direction no read", rd_cnt - r0, 0);

    // R9 high-speed read: long read with address moving after capture
    fast_rd_en = 1'b1;
    w0 = wr_cnt; r0 = rd_cnt;
    access(1'b1, 1'b0, 1'b0, 3'd2, 8'h00, 12, 6, 3'd5, s);
    chk("R9 fast read one pulse", rd_cnt - r0, 1);
    chk("R9 captured address", int'(last_ra), 2);
    chk("R9 read data", int'(s), int'(reg_model(3'd2)));
    // R9 short read: no pulse
    r0 = rd_cnt;
    access(1'b1, 1'b0, 1'b0, 3'd4, 8'h00, 3, -1, 3'd4, s);
    chk("R9 short read no pulse", rd_cnt - r0, 0);
    chk("R9 short read no write", wr_cnt - w0, 0);
    do_wr("R9 fast-mode write", 1'b1, 1'b0, 3'd4, 8'h3E);

    // R11 back to separate strobes, non-multiplexed (A0 toggled by host)
    do_reset();
    do_wr("R11 rw/nonmux first", 1'b0, 1'b0, 3'd1, 8'h11);
    chk("R11 rw style", strobe_ds, 0);
    chk("R3 nonmux from A0", nonmux, 1);
    random_mix("R5 rw/nonmux random", 1'b0, 1'b0, 12);
    chk("R4 locked after mix", locked, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule